// File: doc/BRIEF.md
# Flash Read-Configuration Command Front End

This block sits at the bus edge of a synchronous flash memory model. It decodes command writes and keeps a 16-bit configuration word. It also times the first valid data word of a synchronous read. The data for that word comes from the address lines, not the data lines. A setup opcode is followed by a confirm write, and the value on the address bus during the confirm write becomes the new configuration. An identifier command then lets a host read the word back at a fixed location.

Bus strobes are sampled with the clock. A write stays open while chip enable and write enable are both low. It is committed when the first of three strobes rises: write enable, chip enable or address-valid. Once a read access has started, a small timer counts clock edges from the address-valid pulse. It raises data-valid after the number of clocks that the latency field of the configuration word selects. The design has no input for the programming supply level, so loading the word never depends on it.

Top module: `rcfg_cmd_front`

## Requirements
- R1: After reset the configuration word is FFFFh, the block is in array mode and `data_valid` is low.
- R2: The word is loaded by a write of 60h followed by a write of 03h on `data_in`. The word takes the `addr` value of the 03h write. Both writes may target any address.
- R3: If the write after 60h carries anything other than 03h, the load is aborted and the configuration word keeps its value.
- R4: A write is committed on the first rising edge among `we_n`, `ce_n` and `adv_n`. It stores the address and command sampled on the last clock before that edge. Later rising edges of the same write have no effect.
- R5: After a completed load or an abort the block is in array mode. In array mode every read returns 0000h.
- R6: After a 90h write, a read (`ce_n`=0, `oe_n`=0, `we_n`=1) at address 0005h returns the configuration word. Any other address returns 0000h.
- R7: A write of FFh, or of any unrecognised opcode, outside the setup step returns the block to array mode.
- R8: Bit 15 of the word set to 0 selects synchronous mode. Bits 13:11 hold the latency code L. A clock edge that samples `adv_n`=0, `ce_n`=0 and `we_n`=1 counts as clock 1. `data_valid` is high after clock L for codes 2 to 6, and after clock 7 for codes 0, 1 and 7.
- R9: With bit 15 of the word at 1 (asynchronous mode), `data_valid` never asserts.
- R10: `ce_n` high clears `data_valid` at the next edge. A new `adv_n` low sample restarts the count from clock 1.
- R11: If the edge that commits a load is also the edge that starts an access, the newly loaded word sets that access's mode and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr | input | 16 | Address bus; also carries the configuration value |
| data_in | input | 8 | Command byte written on the data bus |
| data_out | output | 16 | Read data (identifier word or zero) |
| data_valid | output | 1 | First synchronous data word is available |

## Verification
The commit of a configuration load can land on the same clock edge that starts a read access. This happens when write enable rises while chip enable stays low and address-valid has just gone low. The bench sets this up on purpose, starting from the asynchronous reset word and confirming a synchronous word with latency code 2. The new word must govern the access, so `data_valid` is required low after the shared edge and high one edge later. A later identifier read checks that the word was stored.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    // Command decoder state: which kind of read the bus currently gets.
    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_SETUP = 2'd1,
        MODE_IDENT = 2'd2
    } cmd_mode_e;

    // Progress of one bus write cycle through the strobe sampler.
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_OPEN  = 2'd1,
        WR_SPENT = 2'd2
    } wr_phase_e;

endpackage

// File: rtl/rcfg_wr_capture.sv
// Samples the bus strobes and emits one commit per write cycle, on the
// first rising edge among we_n, ce_n and adv_n.
module rcfg_wr_capture
    import rcfg_pkg::*;
#(
    parameter int AW  = 16,
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_n,
    input  logic           we_n,
    input  logic           adv_n,
    input  logic [AW-1:0]  addr,
    input  logic [OPW-1:0] wdata,
    output logic           commit,
    output logic [AW-1:0]  cap_addr,
    output logic [OPW-1:0] cap_data
);

    typedef struct packed {
        wr_phase_e      phase;
        logic           ce_p;
        logic           we_p;
        logic           adv_p;
        logic [AW-1:0]  a;
        logic [OPW-1:0] d;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       rise_any;

    always_comb begin
        st_d       = st_q;
        st_d.ce_p  = ce_n;
        st_d.we_p  = we_n;
        st_d.adv_p = adv_n;
        commit     = 1'b0;
        rise_any   = (ce_n && !st_q.ce_p) || (we_n && !st_q.we_p) ||
                     (adv_n && !st_q.adv_p);
        case (st_q.phase)
            WR_IDLE: begin
                if (!ce_n && !we_n) begin
                    st_d.phase = WR_OPEN;
                    st_d.a     = addr;
                    st_d.d     = wdata;
                end
            end
            WR_OPEN: begin
                if (rise_any) begin
                    // held snapshot is the last sample before the strobe rose
                    commit     = 1'b1;
                    st_d.phase = WR_SPENT;
                end else begin
                    st_d.a = addr;
                    st_d.d = wdata;
                end
            end
            WR_SPENT: begin
                if (ce_n && we_n) begin
                    st_d.phase = WR_IDLE;
                end
            end
            default: st_d.phase = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= WR_IDLE;
            st_q.ce_p  <= 1'b1;
            st_q.we_p  <= 1'b1;
            st_q.adv_p <= 1'b1;
            st_q.a     <= '0;
            st_q.d     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_addr = st_q.a;
    assign cap_data = st_q.d;

endmodule

// File: rtl/rcfg_cmd_decode.sv
// Command state machine and configuration word storage, plus the
// identifier read path.
module rcfg_cmd_decode
    import rcfg_pkg::*;
#(
    parameter int             AW         = 16,
    parameter int             OPW        = 8,
    parameter logic [OPW-1:0] SETUP_OP   = 8'h60,
    parameter logic [OPW-1:0] CONFIRM_OP = 8'h03,
    parameter logic [OPW-1:0] IDENT_OP   = 8'h90,
    parameter logic [AW-1:0]  ID_ADDR    = 16'h0005
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit,
    input  logic [AW-1:0]  cap_addr,
    input  logic [OPW-1:0] cap_data,
    input  logic           rd_sel,
    input  logic [AW-1:0]  addr,
    output logic [AW-1:0]  cfg,
    output cmd_mode_e      mode,
    output logic [AW-1:0]  rdata
);

    typedef struct packed {
        cmd_mode_e     mode;
        logic [AW-1:0] cfg;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            if (st_q.mode == MODE_SETUP) begin
                // confirm loads the word from the address bus, else abort
                if (cap_data == CONFIRM_OP) begin
                    st_d.cfg = cap_addr;
                end
                st_d.mode = MODE_ARRAY;
            end else if (cap_data == SETUP_OP) begin
                st_d.mode = MODE_SETUP;
            end else if (cap_data == IDENT_OP) begin
                st_d.mode = MODE_IDENT;
            end else begin
                st_d.mode = MODE_ARRAY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_ARRAY;
            st_q.cfg  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.cfg;
    assign mode  = st_q.mode;
    assign rdata = (rd_sel && st_q.mode == MODE_IDENT && addr == ID_ADDR) ?
                   st_q.cfg : '0;

endmodule

// File: rtl/rcfg_lat_timer.sv
// Counts clock edges from the address-valid sample of a read access and
// raises data-valid at the configured latency.
module rcfg_lat_timer #(
    parameter int CODE_W   = 3,
    parameter int MAX_LAT  = 7,
    parameter int MIN_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              adv_n,
    input  logic              async_sel,
    input  logic [CODE_W-1:0] code,
    output logic              data_valid
);

    localparam int                CNT_W = $clog2(MAX_LAT + 1);
    localparam logic [CODE_W-1:0] MIN_C = CODE_W'(MIN_CODE);
    localparam logic [CNT_W-1:0]  LAT_TOP = CNT_W'(MAX_LAT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             valid;
    } lat_state_t;

    lat_state_t       st_d, st_q;
    logic [CNT_W-1:0] lat;
    logic [CNT_W-1:0] nxt;

    // reserved, all-ones and out-of-range codes fall back to the longest wait
    function automatic logic [CNT_W-1:0] lat_of(input logic [CODE_W-1:0] c);
        if (c < MIN_C || c == '1 || 32'(c) > MAX_LAT) begin
            return LAT_TOP;
        end
        return CNT_W'(c);
    endfunction

    always_comb begin
        st_d = st_q;
        lat  = lat_of(code);
        nxt  = (st_q.cnt >= lat) ? lat : st_q.cnt + 1'b1;
        if (ce_n) begin
            st_d = '0;
        end else if (!adv_n && we_n) begin
            st_d.cnt   = CNT_W'(1);
            st_d.run   = 1'b1;
            st_d.valid = 1'b0;
        end else if (st_q.run) begin
            st_d.cnt   = nxt;
            st_d.valid = !async_sel && (nxt == lat);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_valid = st_q.valid;

endmodule

// File: rtl/rcfg_cmd_front.sv
module rcfg_cmd_front
    import rcfg_pkg::*;
#(
    parameter int             AW         = 16,
    parameter int             OPW        = 8,
    parameter logic [OPW-1:0] SETUP_OP   = 8'h60,
    parameter logic [OPW-1:0] CONFIRM_OP = 8'h03,
    parameter logic [OPW-1:0] IDENT_OP   = 8'h90,
    parameter logic [AW-1:0]  ID_ADDR    = 16'h0005,
    parameter int             SYNC_BIT   = 15,
    parameter int             CODE_LSB   = 11,
    parameter int             CODE_W     = 3,
    parameter int             MAX_LAT    = 7,
    parameter int             MIN_CODE   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_n,
    input  logic           we_n,
    input  logic           oe_n,
    input  logic           adv_n,
    input  logic [AW-1:0]  addr,
    input  logic [OPW-1:0] data_in,
    output logic [AW-1:0]  data_out,
    output logic           data_valid
);

    logic           commit_w;
    logic [AW-1:0]  cap_addr_w;
    logic [OPW-1:0] cap_data_w;
    logic [AW-1:0]  cfg_w;
    cmd_mode_e      mode_w;
    logic           rd_sel_w;

    assign rd_sel_w = !ce_n && !oe_n && we_n;

    rcfg_wr_capture #(
        .AW  (AW),
        .OPW (OPW)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .adv_n    (adv_n),
        .addr     (addr),
        .wdata    (data_in),
        .commit   (commit_w),
        .cap_addr (cap_addr_w),
        .cap_data (cap_data_w)
    );

    rcfg_cmd_decode #(
        .AW         (AW),
        .OPW        (OPW),
        .SETUP_OP   (SETUP_OP),
        .CONFIRM_OP (CONFIRM_OP),
        .IDENT_OP   (IDENT_OP),
        .ID_ADDR    (ID_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit_w),
        .cap_addr (cap_addr_w),
        .cap_data (cap_data_w),
        .rd_sel   (rd_sel_w),
        .addr     (addr),
        .cfg      (cfg_w),
        .mode     (mode_w),
        .rdata    (data_out)
    );

    rcfg_lat_timer #(
        .CODE_W   (CODE_W),
        .MAX_LAT  (MAX_LAT),
        .MIN_CODE (MIN_CODE)
    ) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .adv_n      (adv_n),
        .async_sel  (cfg_w[SYNC_BIT]),
        .code       (cfg_w[CODE_LSB +: CODE_W]),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/rcfg_cmd_front_chk.sv
module rcfg_cmd_front_chk
    import rcfg_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SYNC_BIT = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          adv_n,
    input logic          data_valid,
    input logic          commit,
    input logic [AW-1:0] cfg,
    input cmd_mode_e     mode,
    input logic [AW-1:0] data_out
);

    // R2: the word only moves on an edge that saw a commit
    assert_cfg_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg));

    // R3: a change of the word always follows the setup step
    assert_cfg_needs_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(mode) == MODE_SETUP);

    // R4: one write cycle yields a single commit
    assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6: nonzero read data only during an identifier read
    assert_out_only_ident_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_out != '0) |-> (!ce_n && !oe_n && we_n && mode == MODE_IDENT));

    // R8: the starting edge of an access never already shows valid data
    assert_start_not_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_n && !ce_n && we_n) |=> !data_valid);

    // R9: asynchronous mode keeps data-valid low
    assert_async_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg[SYNC_BIT]) |-> !data_valid);

    // R10: chip enable high clears data-valid
    assert_ce_clears_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !data_valid);

endmodule

bind rcfg_cmd_front rcfg_cmd_front_chk #(
    .AW       (AW),
    .SYNC_BIT (SYNC_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .adv_n      (adv_n),
    .data_valid (data_valid),
    .commit     (commit_w),
    .cfg        (cfg_w),
    .mode       (mode_w),
    .data_out   (data_out)
);

// File: tb/tb_rcfg_cmd_front.sv
`timescale 1ns/1ps
module tb_rcfg_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, we_n, oe_n, adv_n;
    logic [15:0] addr;
    logic [7:0]  data_in;
    logic [15:0] data_out;
    logic        data_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rcfg_cmd_front dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .adv_n      (adv_n),
        .addr       (addr),
        .data_in    (data_in),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    // {latency code, expected clock of first valid data}
    localparam logic [6:0] LAT_TAB [8] = '{
        {3'd2, 4'd2}, {3'd3, 4'd3}, {3'd4, 4'd4}, {3'd5, 4'd5},
        {3'd6, 4'd6}, {3'd0, 4'd7}, {3'd1, 4'd7}, {3'd7, 4'd7}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
        addr = 16'h0000; data_in = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b1;
        @(negedge clk);
        v = data_out;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic load_cfg(input logic [15:0] v);
        bus_write(16'h3F00, 8'h60);
        bus_write(v, 8'h03);
    endtask

    task automatic ident_read(output logic [15:0] v);
        bus_write(16'h0000, 8'h90);
        bus_read(16'h0005, v);
    endtask

    // returns the clock number of the first valid sample, 0 if none
    task automatic measure(output int first);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; adv_n = 1'b0;
        first = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (data_valid && first == 0) first = k;
            if (k == 1) adv_n = 1'b1;
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R10 ce_n high clears data_valid", data_valid, 1'b0);
    endtask

    // which: 0 = we_n first, 1 = ce_n first, 2 = adv_n first
    task automatic strobe_race(input int which, input logic [15:0] a1,
                               input logic [15:0] a2);
        bus_write(16'hBEEF, 8'h60);
        @(negedge clk);
        addr = a1; data_in = 8'h03; ce_n = 1'b0; we_n = 1'b0; adv_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        case (which)
            0: we_n = 1'b1;
            1: ce_n = 1'b1;
            default: adv_n = 1'b1;
        endcase
        @(negedge clk);
        addr = a2; data_in = 8'h55;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; adv_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] rv;
        int          first;
        rst_n = 1'b1;
        bus_idle();
        do_reset();

        // R1: reset state
        check("R1 data_valid low after reset", data_valid, 1'b0);
        bus_read(16'h0005, rv);
        check("R5 array mode after reset reads zero", rv, 16'h0000);
        ident_read(rv);
        check("R1 reset word all ones", rv, 16'hFFFF);

        // R9: asynchronous reset word never raises data-valid
        measure(first);
        check("R9 async mode no data_valid", first, 0);

        // R2 / R5 / R6: load at arbitrary addresses and read back
        bus_write(16'h7FFF, 8'h60);
        bus_write(16'h4321, 8'h03);
        bus_read(16'h0005, rv);
        check("R5 array mode after load", rv, 16'h0000);
        ident_read(rv);
        check("R2 loaded word from address bus", rv, 16'h4321);
        bus_read(16'h0004, rv);
        check("R6 other identifier address reads zero", rv, 16'h0000);

        // R7: FFh returns to array mode
        bus_write(16'h0005, 8'hFF);
        bus_read(16'h0005, rv);
        check("R7 FFh leaves identifier mode", rv, 16'h0000);

        // R3: wrong confirm aborts
        bus_write(16'h0000, 8'h60);
        bus_write(16'h1234, 8'h55);
        bus_read(16'h0005, rv);
        check("R5 array mode after abort", rv, 16'h0000);
        ident_read(rv);
        check("R3 abort keeps word", rv, 16'h4321);

        // R8: latency table walk
        for (int i = 0; i < 8; i++) begin
            load_cfg({1'b0, 2'b00, LAT_TAB[i][6:4], 11'h000});
            measure(first);
            check($sformatf("R8 latency for code %0d", LAT_TAB[i][6:4]),
                  first, 32'(LAT_TAB[i][3:0]));
        end

        // R4: first rising strobe wins, for each strobe
        strobe_race(0, 16'h2D5A, 16'hC3A5);
        ident_read(rv);
        check("R4 we_n first capture", rv, 16'h2D5A);
        strobe_race(1, 16'h1B3C, 16'hE4F0);
        ident_read(rv);
        check("R4 ce_n first capture", rv, 16'h1B3C);
        strobe_race(2, 16'h0A0F, 16'h5F50);
        ident_read(rv);
        check("R4 adv_n first capture", rv, 16'h0A0F);

        // R10: restart on a second adv_n low (code 4)
        load_cfg(16'h2000);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; adv_n = 1'b0;
        first = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (data_valid && first == 0) first = k;
            if (k == 1) adv_n = 1'b1;
            if (k == 3) adv_n = 1'b0;
            if (k == 4) adv_n = 1'b1;
        end
        ce_n = 1'b1; oe_n = 1'b1;
        check("R10 restart delays data_valid", first, 7);

        // R11: load commit and access start on the same edge
        do_reset();
        bus_write(16'h0000, 8'h60);
        @(negedge clk);
        addr = 16'h1000; data_in = 8'h03; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; adv_n = 1'b0;
        @(negedge clk);
        check("R11 shared edge not yet valid", data_valid, 1'b0);
        adv_n = 1'b1;
        @(negedge clk);
        check("R11 new word sets latency 2", data_valid, 1'b1);
        ce_n = 1'b1;
        @(negedge clk);
        ident_read(rv);
        check("R11 word stored", rv, 16'h1000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule